// File: doc/BRIEF.md
# Byte-Lane Read Pattern Checker

This block judges one byte lane of a 64-bit memory read path during read-delay calibration. A sequencer writes a known 40-word pattern into a 320-byte region of every rank. It then reads the region back as a stream of 32-bit words, each tagged with its byte offset, and feeds that stream to this checker. The checker knows the pattern as a built-in constant. It picks the word of each 8-byte pair and the byte within that word that belong to the selected lane, and compares only that byte.

A start pulse captures the lane number and the number of ranks, then arms the check. The checker expects entries 0 to 39 in order for each rank, with the entry index starting again at 0 for every new rank. A mismatch on any expected read ends the run at once with a fail verdict. When every entry of every rank has matched, the run ends with a pass verdict. A read whose offset is not the one the checker awaits is ignored. The verdict is held until the next start.

Top module: `lane_pattern_checker`

## Requirements
- R1: While reset is low, and on the first cycle after it, `busy`, `pass` and `fail` are all 0.
- R2: A `start` pulse captures `lane_sel` and `rank_count` and clears both verdicts. On the next cycle `busy` is 1 and the check awaits entry 0 of the first rank. A `start` during a run restarts it. A `rank_count` of 0 is treated as 1, and a value above 4 is treated as 4.
- R3: Entry k is expected at byte offset 8*k when `lane_sel[2]` is 0, and at 8*k+4 when `lane_sel[2]` is 1.
- R4: Only byte `lane_sel[1:0]` of the word is compared, that is bits [8*b+7:8*b] with b = `lane_sel[1:0]`. Differences in the other three bytes have no effect.
- R5: The first expected read whose lane byte differs from the pattern sets `fail` and clears `busy` in the cycle after that read. Both values are then held.
- R6: After entries 0..39 have all matched for each of the captured number of ranks, `pass` is set and `busy` cleared in the cycle after the last read. Completing an earlier rank leaves `busy` at 1 and `pass` at 0.
- R7: While busy, a valid read whose offset differs from the awaited offset changes no state, whatever its data.
- R8: While not busy, valid reads have no effect on `pass`, `fail` or `busy`.
- R9: Every byte of pattern entry k equals the same value. Entries 0..7 carry the walking-zero bytes FE 7F BE DF EE F7 FA FD. Entries 8..15 carry the walking-one bytes 00 81 40 21 10 09 04 03. Entries 16..31 carry 10 11 EE EF 10 11 EE EF 10 EF 10 EF 10 EF 10 EF. Entries 32..39 carry 00 FF 00 FF 00 FF 00 00.
- R10: `pass` and `fail` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new check; captures lane and rank count |
| lane_sel | input | 3 | Byte lane 0..7 of the 64-bit bus |
| rank_count | input | 3 | Number of ranks to check, 1..4 |
| rd_valid | input | 1 | Read word qualifier |
| rd_offset | input | 9 | Byte offset of the read word within the test region |
| rd_data | input | 32 | Read-back data word |
| busy | output | 1 | A check is in progress |
| pass | output | 1 | Last check matched everywhere |
| fail | output | 1 | Last check saw a mismatch |

## Verification
Some properties are checked by assertions on every cycle. The verdicts never overlap. A start always clears the verdicts and arms the check. An off-offset read or an idle-time read leaves the progress and the verdicts unchanged. The entry index stays inside the pattern. Other behaviour only the bench scenarios can show. These are the actual pattern bytes, the lane-to-word and lane-to-byte mapping, the restart of the entry count per rank, and the exact cycle in which a pass or fail appears. They are checked by runs over all eight lanes, with corrupted bytes inside and outside the selected lane and with stray reads between the expected words.

// File: rtl/bl_chk_pkg.sv
// Package for the byte-lane pattern checker.
// Holds the pattern geometry and the constant pattern ROM function.
// Assumes one byte value per entry, replicated across the data word.
package bl_chk_pkg;
    localparam int ENTRIES    = 40;
    localparam int PAIR_BYTES = 8;
    localparam int WORD_BYTES = 4;
    localparam int IDX_W      = $clog2(ENTRIES);
    localparam int OFF_W      = $clog2(ENTRIES * PAIR_BYTES);

    // Expected byte value of pattern entry k.
    function automatic logic [7:0] pattern_byte(input logic [IDX_W-1:0] k);
        logic [7:0] b;
        case (k)
            6'd0:  b = 8'hFE;  6'd1:  b = 8'h7F;  6'd2:  b = 8'hBE;  6'd3:  b = 8'hDF;
            6'd4:  b = 8'hEE;  6'd5:  b = 8'hF7;  6'd6:  b = 8'hFA;  6'd7:  b = 8'hFD;
            6'd8:  b = 8'h00;  6'd9:  b = 8'h81;  6'd10: b = 8'h40;  6'd11: b = 8'h21;
            6'd12: b = 8'h10;  6'd13: b = 8'h09;  6'd14: b = 8'h04;  6'd15: b = 8'h03;
            6'd16: b = 8'h10;  6'd17: b = 8'h11;  6'd18: b = 8'hEE;  6'd19: b = 8'hEF;
            6'd20: b = 8'h10;  6'd21: b = 8'h11;  6'd22: b = 8'hEE;  6'd23: b = 8'hEF;
            6'd24: b = 8'h10;  6'd25: b = 8'hEF;  6'd26: b = 8'h10;  6'd27: b = 8'hEF;
            6'd28: b = 8'h10;  6'd29: b = 8'hEF;  6'd30: b = 8'h10;  6'd31: b = 8'hEF;
            6'd33: b = 8'hFF;  6'd35: b = 8'hFF;  6'd37: b = 8'hFF;
            default: b = 8'h00;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/bl_pattern_rom.sv
// Constant pattern ROM: maps an entry index to the expected data word.
// Assumes the index is below ENTRIES; every byte of a word is the same.
module bl_pattern_rom
    import bl_chk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    localparam int BYTES = DATA_W / 8;

    // Replicate the entry byte across the word.
    always_comb word = {BYTES{pattern_byte(idx)}};
endmodule

// File: rtl/bl_lane_decode.sv
// Lane decode: the lane number gives the awaited byte offset for an entry
// and the compare mask. Assumes 8-byte word pairs and 8-bit lanes.
module bl_lane_decode
    import bl_chk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        lane,
    input  logic [IDX_W-1:0]  idx,
    output logic [OFF_W-1:0]  exp_off,
    output logic [DATA_W-1:0] mask
);
    localparam logic [OFF_W-1:0] PAIR = OFF_W'(PAIR_BYTES);
    localparam logic [OFF_W-1:0] HALF = OFF_W'(WORD_BYTES);

    // Upper word of the pair for lanes 4..7, lower word otherwise.
    always_comb exp_off = OFF_W'(idx) * PAIR + (lane[2] ? HALF : '0);

    // One byte of ones, moved to the lane's byte.
    always_comb mask = DATA_W'(8'hFF) << (8 * lane[1:0]);
endmodule

// File: rtl/bl_progress.sv
// Progress counter: entry index within a rank and rank number.
// Assumes ranks_q is 1..MAX_RANKS and is stable between clears.
module bl_progress
    import bl_chk_pkg::*;
#(
    parameter int MAX_RANKS = 4,
    localparam int RANK_W   = $clog2(MAX_RANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [RANK_W-1:0] ranks_q,
    output logic [IDX_W-1:0]  idx,
    output logic              last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [RANK_W-1:0] rank;
    logic              last_entry;

    // Decode the end of a rank and the end of the whole run.
    always_comb begin
        last_entry = (idx == LAST_IDX);
        last       = last_entry && (rank == ranks_q - RANK_W'(1));
    end

    // Step through the entries; restart the index at each new rank.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx  <= '0;
            rank <= '0;
        end else if (advance) begin
            if (last_entry) begin
                idx  <= '0;
                rank <= rank + RANK_W'(1);
            end else begin
                idx  <= idx + IDX_W'(1);
            end
        end
    end

    p_idx_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idx < IDX_W'(ENTRIES));

    p_hold_without_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> ($stable(idx) && $stable(rank)));
endmodule

// File: rtl/lane_pattern_checker.sv
// Top of the byte-lane pattern checker. Compares the selected byte of each
// awaited read word against the constant pattern, over all captured ranks.
// Assumes the read stream presents each entry at its byte offset; other
// offsets are ignored. The verdict holds until the next start.
module lane_pattern_checker
    import bl_chk_pkg::*;
#(
    parameter int MAX_RANKS = 4,
    parameter int DATA_W    = 32,
    localparam int RANK_W   = $clog2(MAX_RANKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        lane_sel,
    input  logic [RANK_W-1:0] rank_count,
    input  logic              rd_valid,
    input  logic [OFF_W-1:0]  rd_offset,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              pass,
    output logic              fail
);
    logic [2:0]        lane_q;
    logic [RANK_W-1:0] ranks_q;
    logic [RANK_W-1:0] ranks_in;
    logic [IDX_W-1:0]  idx;
    logic [OFF_W-1:0]  exp_off;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] exp_word;
    logic              last;
    logic              hit;
    logic              match;

    // Clamp the requested rank count into 1..MAX_RANKS.
    always_comb begin
        if (rank_count == '0)
            ranks_in = RANK_W'(1);
        else if (rank_count > RANK_W'(MAX_RANKS))
            ranks_in = RANK_W'(MAX_RANKS);
        else
            ranks_in = rank_count;
    end

    bl_lane_decode #(.DATA_W(DATA_W)) i_decode (
        .lane    (lane_q),
        .idx     (idx),
        .exp_off (exp_off),
        .mask    (mask)
    );

    bl_pattern_rom #(.DATA_W(DATA_W)) i_rom (
        .idx  (idx),
        .word (exp_word)
    );

    // Awaited read arrives; compare its lane byte.
    always_comb begin
        hit   = busy && rd_valid && !start && (rd_offset == exp_off);
        match = ((rd_data ^ exp_word) & mask) == '0;
    end

    bl_progress #(.MAX_RANKS(MAX_RANKS)) i_progress (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .advance (hit && match),
        .ranks_q (ranks_q),
        .idx     (idx),
        .last    (last)
    );

    // Run control and verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
            lane_q  <= '0;
            ranks_q <= RANK_W'(1);
        end else if (start) begin
            busy    <= 1'b1;
            pass    <= 1'b0;
            fail    <= 1'b0;
            lane_q  <= lane_sel;
            ranks_q <= ranks_in;
        end else if (hit) begin
            if (!match) begin
                fail <= 1'b1;
                busy <= 1'b0;
            end else if (last) begin
                pass <= 1'b1;
                busy <= 1'b0;
            end
        end
    end

    p_verdict_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !pass && !fail));

    p_fail_ends_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> !busy);

    p_stray_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_valid && !start && rd_offset != exp_off)
            |=> (busy && $stable(pass) && $stable(fail)));

    p_idle_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (!busy && $stable(pass) && $stable(fail)));
endmodule

// File: tb/test_lane_pattern_checker.sv
module test_lane_pattern_checker;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENT      = 40;
    localparam int NONE       = 127;

    localparam logic [7:0] PAT [N_ENT] = '{
        8'hFE, 8'h7F, 8'hBE, 8'hDF, 8'hEE, 8'hF7, 8'hFA, 8'hFD,
        8'h00, 8'h81, 8'h40, 8'h21, 8'h10, 8'h09, 8'h04, 8'h03,
        8'h10, 8'h11, 8'hEE, 8'hEF, 8'h10, 8'h11, 8'hEE, 8'hEF,
        8'h10, 8'hEF, 8'h10, 8'hEF, 8'h10, 8'hEF, 8'h10, 8'hEF,
        8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00};

    typedef struct packed {
        logic [2:0]  lane;
        logic [2:0]  ranks;
        logic [2:0]  bad_rank;
        logic [6:0]  bad_entry;
        logic [31:0] flip;
        logic        exp_pass;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 3'd1, 3'd0, 7'd127, 32'h0000_0000, 1'b1},
        '{3'd5, 3'd2, 3'd0, 7'd127, 32'h0000_0000, 1'b1},
        '{3'd3, 3'd1, 3'd0, 7'd0,   32'hFF00_0000, 1'b0},
        '{3'd2, 3'd1, 3'd0, 7'd10,  32'hFF00_0000, 1'b1},
        '{3'd7, 3'd4, 3'd3, 7'd39,  32'h8000_0000, 1'b0},
        '{3'd4, 3'd3, 3'd0, 7'd127, 32'h0000_0000, 1'b1},
        '{3'd1, 3'd2, 3'd1, 7'd20,  32'h0000_0100, 1'b0},
        '{3'd6, 3'd1, 3'd0, 7'd39,  32'h0000_00FF, 1'b1},
        '{3'd0, 3'd0, 3'd0, 7'd127, 32'h0000_0000, 1'b1}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  lane_sel = '0;
    logic [2:0]  rank_count = '0;
    logic        rd_valid = 1'b0;
    logic [8:0]  rd_offset = '0;
    logic [31:0] rd_data = '0;
    logic        busy, pass, fail;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_pattern_checker i_lane_pattern_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .lane_sel(lane_sel),
        .rank_count(rank_count), .rd_valid(rd_valid), .rd_offset(rd_offset),
        .rd_data(rd_data), .busy(busy), .pass(pass), .fail(fail));

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        start = 1'b0;
        rd_valid = 1'b0;
    endtask

    task automatic pulse_start(input logic [2:0] ln, input logic [2:0] rk);
        @(negedge clk);
        start = 1'b1;
        lane_sel = ln;
        rank_count = rk;
        rd_valid = 1'b0;
    endtask

    task automatic drive_read(input logic [8:0] off, input logic [31:0] d);
        @(negedge clk);
        start = 1'b0;
        rd_valid = 1'b1;
        rd_offset = off;
        rd_data = d;
    endtask

    function automatic logic [8:0] real_off(input int k, input logic [2:0] ln);
        return 9'(k * 8 + (ln[2] ? 4 : 0));
    endfunction

    function automatic logic [8:0] stray_off(input int k, input logic [2:0] ln);
        return 9'(k * 8 + (ln[2] ? 0 : 4));
    endfunction

    // One table vector: all ranks, stray read before every real read (R7).
    task automatic run_vector(input vec_t v);
        int nr;
        nr = (v.ranks == 0) ? 1 : int'(v.ranks);
        pulse_start(v.lane, v.ranks);
        for (int r = 0; r < nr; r++) begin
            for (int k = 0; k < N_ENT; k++) begin
                logic [31:0] w;
                w = {4{PAT[k]}};
                drive_read(stray_off(k, v.lane), ~w);
                if (r == int'(v.bad_rank) && k == int'(v.bad_entry))
                    w = w ^ v.flip;
                drive_read(real_off(k, v.lane), w);
            end
            if (r < nr - 1) begin
                idle_cycle();
                if (v.exp_pass) begin
                    check("R6 rank boundary busy", busy, 1'b1);
                    check("R6 rank boundary pass", pass, 1'b0);
                end
            end
        end
        idle_cycle();
        check("R3/R4/R6 pass verdict", pass, v.exp_pass);
        check("R5 fail verdict", fail, !v.exp_pass);
        check("R5/R6 busy cleared", busy, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 1'b0);
        check("R1 pass in reset", pass, 1'b0);
        check("R1 fail in reset", fail, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        idle_cycle();
        check("R1 busy after reset", busy, 1'b0);

        // R8: reads while idle have no effect
        drive_read(9'd0, 32'hFEFE_FEFE);
        drive_read(9'd8, 32'h1234_5678);
        idle_cycle();
        check("R8 idle busy", busy, 1'b0);
        check("R8 idle pass", pass, 1'b0);
        check("R8 idle fail", fail, 1'b0);

        // Table of vectors
        for (int i = 0; i < NV; i++) run_vector(VECS[i]);

        // R9: walking-zero entries accepted, wrong byte at entry 8 fails
        pulse_start(3'd0, 3'd1);
        idle_cycle();
        check("R2 busy after start", busy, 1'b1);
        check("R2 verdict cleared", pass, 1'b0);
        for (int k = 0; k < 8; k++) drive_read(real_off(k, 3'd0), {4{PAT[k]}});
        idle_cycle();
        check("R9 walking-zero entries match", busy, 1'b1);
        drive_read(real_off(8, 3'd0), 32'hFEFE_FEFE);
        idle_cycle();
        check("R9 entry 8 is not FE", fail, 1'b1);

        // R2: start clears a held fail; restart mid-run begins at entry 0
        pulse_start(3'd4, 3'd1);
        idle_cycle();
        check("R2 start clears fail", fail, 1'b0);
        for (int k = 0; k < 5; k++) drive_read(real_off(k, 3'd4), {4{PAT[k]}});
        pulse_start(3'd1, 3'd1);
        for (int k = 0; k < N_ENT; k++) drive_read(real_off(k, 3'd1), {4{PAT[k]}});
        idle_cycle();
        check("R2 restart runs full pattern", pass, 1'b1);

        // R7: awaited offset skipped keeps the run waiting
        pulse_start(3'd2, 3'd1);
        drive_read(real_off(1, 3'd2), 32'h0000_0000);
        drive_read(9'd3, 32'h0000_0000);
        idle_cycle();
        check("R7 off-offset reads ignored busy", busy, 1'b1);
        check("R7 off-offset reads ignored fail", fail, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule